// File: doc/BRIEF.md
# Time-Triggered Output Generator Bank

This block holds a small bank of trigger units. Each unit watches a free-running time-of-day value supplied from outside: whole seconds, nanoseconds, and a tick that marks each 8 ns step. Software programs a unit with an absolute target time and an output pattern, then arms it. When the time value first reaches or passes the target, the unit acts on one of the shared output lines. It can set a level, make a rising or falling step, make one high or low pulse of a set length, or run a train of pulses with a set period. The train can run a set number of cycles or without end.

All software access goes through a flat register port with a write strobe and a combinational read. A unit-select register decides which unit the per-unit registers reach. Status flags are kept per unit and are cleared by writing ones. A global stop bit idles every unit and leaves the lines at their present levels. Where several units drive the same line in one cycle, the lower-numbered unit wins.

Top module: `trig_out_bank`

## Requirements
- R1: After reset all output lines are low, irq is low and both status registers read zero.
- R2: Register byte offsets are 0x00 unit select (bits 1:0), 0x04 trigger status, 0x08 interrupt status, 0x0C control, 0x10 target nanoseconds, 0x14 target seconds, 0x18 unit setup, 0x1C period in ns, 0x20 cycle count (bits 31:16), and 0x24 pulse width in 8 ns ticks (bits 23:0). The unit setup register holds the pattern in bits 2:0, the line in bits 7:4, notify in bit 8 and a level in bit 9. The per-unit registers reach only the selected unit. A select value with no unit behind it reads zero and writes nothing.
- R3: The first output event happens on the first clock edge at which {seconds, nanoseconds} is at or above {target seconds, target nanoseconds}. The comparison treats the pair as one number, so a target just past a seconds boundary fires only after the seconds value steps.
- R4: Patterns 0 (falling step), 1 (rising step) and 6 (drive the level bit) change the line once at the event and set the unit's done flag at once.
- R5: Patterns 2 (low pulse) and 3 (high pulse) hold the line active for exactly width ticks, then return it to idle and set done. A width of 0 acts as 1.
- R6: Patterns 4 (low-going train) and 5 (high-going train) start a pulse every period/8 ticks, each pulse width ticks long. With a nonzero count N the unit makes N pulses, leaves the line idle and sets done. A width at or above the period keeps the line active for the whole train.
- R7: A train with a cycle count of 0 runs until it is stopped and never sets done.
- R8: When a unit sets done with notify set, its interrupt flag is raised and irq goes high. Without notify the interrupt flag stays clear.
- R9: Arming a unit whose target is already earlier than the current time sets its error flag. The unit stays idle and drives nothing.
- R10: The trigger status register holds error flags in bits 18:16 and done flags in bits 2:0. The interrupt status register holds interrupt flags in bits 18:16. Writing 1 to a flag bit clears it.
- R11: A control write with bit 0 set stops every unit and clears every enable. No output line changes level as a result.
- R12: A control write with bits 1 (enable) and 2 (output direction) set arms the selected unit. A write with bit 1 clear stops only that unit. On read, bit 1 shows whether the unit is enabled and bit 3 whether it is generating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| todSec | input | 32 | Time-of-day seconds |
| todNs | input | 30 | Time-of-day nanoseconds |
| todTick | input | 1 | High in each cycle in which the time advanced by 8 ns |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Register byte address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| outLines | output | 4 | Output line levels |
| irq | output | 1 | Any interrupt flag set |

## Verification
A wrong compare or counter state shows up at once as a line edge at the wrong time-of-day value. The bench can read that value back to the nanosecond in the sample after the edge. A tick counter that drifts shows in the same train as a pulse length or spacing that is off by whole ticks. A done or interrupt flag that is set wrongly, or never set, shows in the status registers read right after the pattern ends. Stop and disarm faults show as a line that moves during the quiet window watched after the write.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int TGT_W   = 32;
  localparam int PER_W   = 32;
  localparam int CNT_W   = 16;
  localparam int WID_W   = 24;
  localparam int LSEL_W  = 4;
  localparam int FLAG_HI = 16;

  localparam int OFS_SEL    = 'h00;
  localparam int OFS_TSTAT  = 'h04;
  localparam int OFS_ISTAT  = 'h08;
  localparam int OFS_CTRL   = 'h0C;
  localparam int OFS_TNS    = 'h10;
  localparam int OFS_TSEC   = 'h14;
  localparam int OFS_SETUP  = 'h18;
  localparam int OFS_PERIOD = 'h1C;
  localparam int OFS_CNT    = 'h20;
  localparam int OFS_WIDTH  = 'h24;

  typedef enum logic [2:0] {
    PAT_FALL      = 3'd0,
    PAT_RISE      = 3'd1,
    PAT_LOWPULSE  = 3'd2,
    PAT_HIGHPULSE = 3'd3,
    PAT_LOWTRAIN  = 3'd4,
    PAT_HIGHTRAIN = 3'd5,
    PAT_LEVEL     = 3'd6,
    PAT_NONE      = 3'd7
  } pattern_e;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} unit_state_e;

  typedef struct packed {
    logic [TGT_W-1:0]  tgtSec;
    logic [TGT_W-1:0]  tgtNs;
    pattern_e          pattern;
    logic [LSEL_W-1:0] lineSel;
    logic              notify;
    logic              levelVal;
    logic [PER_W-1:0]  periodNs;
    logic [CNT_W-1:0]  cycCount;
    logic [WID_W-1:0]  widthTicks;
  } unit_cfg_t;

  typedef struct packed {
    logic arm;
    logic disarm;
    logic halt;
  } unit_strobe_t;
endpackage

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_pkg::*;
#(
  parameter int NUM_UNITS = 3,
  parameter int ADDR_W    = 6,
  parameter int IDX_W     = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWrEn,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [31:0]                   regWdata,
  output logic [31:0]                   regRdata,
  input  logic [NUM_UNITS-1:0]          evDone,
  input  logic [NUM_UNITS-1:0]          evErr,
  input  logic [NUM_UNITS-1:0]          unitBusy,
  input  logic [NUM_UNITS-1:0]          unitActive,
  output unit_cfg_t [NUM_UNITS-1:0]     unitCfg,
  output unit_strobe_t [NUM_UNITS-1:0]  strobe,
  output logic [NUM_UNITS-1:0]          errFlags,
  output logic [NUM_UNITS-1:0]          doneFlags,
  output logic [NUM_UNITS-1:0]          intFlags,
  output logic                          irq
);
  logic [IDX_W-1:0] unitSel;
  logic             selValid;
  logic             ctrlWr;

  function automatic logic hit(input int ofs);
    return regAddr == ADDR_W'(ofs);
  endfunction

  assign selValid = int'(unitSel) < NUM_UNITS;
  assign ctrlWr   = regWrEn && hit(OFS_CTRL);
  assign irq      = |intFlags;

  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      strobe[u].halt   = ctrlWr && regWdata[0];
      strobe[u].arm    = ctrlWr && !regWdata[0] && regWdata[1] && regWdata[2]
                         && int'(unitSel) == u;
      strobe[u].disarm = ctrlWr && !regWdata[0] && !regWdata[1]
                         && int'(unitSel) == u;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unitSel   <= '0;
      unitCfg   <= '0;
      errFlags  <= '0;
      doneFlags <= '0;
      intFlags  <= '0;
    end else begin
      if (regWrEn && hit(OFS_SEL)) unitSel <= regWdata[IDX_W-1:0];
      for (int u = 0; u < NUM_UNITS; u++) begin
        if (regWrEn && int'(unitSel) == u) begin
          if (hit(OFS_TNS))    unitCfg[u].tgtNs      <= regWdata;
          if (hit(OFS_TSEC))   unitCfg[u].tgtSec     <= regWdata;
          if (hit(OFS_PERIOD)) unitCfg[u].periodNs   <= regWdata;
          if (hit(OFS_CNT))    unitCfg[u].cycCount   <= regWdata[31:16];
          if (hit(OFS_WIDTH))  unitCfg[u].widthTicks <= regWdata[WID_W-1:0];
          if (hit(OFS_SETUP)) begin
            unitCfg[u].pattern  <= pattern_e'(regWdata[2:0]);
            unitCfg[u].lineSel  <= regWdata[7:4];
            unitCfg[u].notify   <= regWdata[8];
            unitCfg[u].levelVal <= regWdata[9];
          end
        end
        if (regWrEn && hit(OFS_TSTAT)) begin
          if (regWdata[FLAG_HI+u]) errFlags[u]  <= 1'b0;
          if (regWdata[u])         doneFlags[u] <= 1'b0;
        end
        if (regWrEn && hit(OFS_ISTAT) && regWdata[FLAG_HI+u]) intFlags[u] <= 1'b0;
        if (evErr[u]) errFlags[u] <= 1'b1;
        if (evDone[u]) begin
          doneFlags[u] <= 1'b1;
          if (unitCfg[u].notify) intFlags[u] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (hit(OFS_SEL)) regRdata[IDX_W-1:0] = unitSel;
    if (hit(OFS_TSTAT)) begin
      regRdata[FLAG_HI +: NUM_UNITS] = errFlags;
      regRdata[NUM_UNITS-1:0]        = doneFlags;
    end
    if (hit(OFS_ISTAT)) regRdata[FLAG_HI +: NUM_UNITS] = intFlags;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (selValid && int'(unitSel) == u) begin
        if (hit(OFS_CTRL)) begin
          regRdata[1] = unitBusy[u];
          regRdata[3] = unitActive[u];
        end
        if (hit(OFS_TNS))    regRdata = unitCfg[u].tgtNs;
        if (hit(OFS_TSEC))   regRdata = unitCfg[u].tgtSec;
        if (hit(OFS_PERIOD)) regRdata = unitCfg[u].periodNs;
        if (hit(OFS_CNT))    regRdata = {unitCfg[u].cycCount, 16'b0};
        if (hit(OFS_WIDTH))  regRdata = {{(32-WID_W){1'b0}}, unitCfg[u].widthTicks};
        if (hit(OFS_SETUP))  regRdata = {22'b0, unitCfg[u].levelVal, unitCfg[u].notify,
                                         unitCfg[u].lineSel, 1'b0, unitCfg[u].pattern};
      end
    end
  end
endmodule

// File: rtl/trig_unit.sv
module trig_unit
  import trig_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int NS_W  = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  unit_strobe_t      strobe,
  input  unit_cfg_t         cfg,
  input  logic [SEC_W-1:0]  todSec,
  input  logic [NS_W-1:0]   todNs,
  input  logic              todTick,
  output logic              drvEn,
  output logic [LSEL_W-1:0] drvLine,
  output logic              drvLevel,
  output logic              evDone,
  output logic              evErr,
  output logic              busy,
  output logic              active
);
  localparam int TIME_W = SEC_W + TGT_W;

  unit_state_e      state;
  logic [PER_W-1:0] elapsed;
  logic [CNT_W-1:0] cycDone;

  logic [TIME_W-1:0] nowTime, tgtTime;
  logic [PER_W-1:0]  perTicks, widTicks, elapsedNext;
  logic reached, inPast, isTrain, isPulse, actLvl, perEnd, pulEnd, lastCyc;

  assign nowTime     = {todSec, {(TGT_W-NS_W){1'b0}}, todNs};
  assign tgtTime     = {cfg.tgtSec, cfg.tgtNs};
  assign reached     = nowTime >= tgtTime;
  assign inPast      = nowTime > tgtTime;
  assign isTrain     = cfg.pattern == PAT_LOWTRAIN || cfg.pattern == PAT_HIGHTRAIN;
  assign isPulse     = cfg.pattern == PAT_LOWPULSE || cfg.pattern == PAT_HIGHPULSE;
  assign perTicks    = (cfg.periodNs[PER_W-1:3] == '0) ? PER_W'(1)
                                                       : {3'b0, cfg.periodNs[PER_W-1:3]};
  assign widTicks    = (cfg.widthTicks == '0) ? PER_W'(1) : PER_W'(cfg.widthTicks);
  assign elapsedNext = elapsed + PER_W'(1);
  assign perEnd      = isTrain && todTick && elapsedNext == perTicks;
  assign pulEnd      = todTick && elapsedNext == widTicks;
  assign lastCyc     = cfg.cycCount != '0 && (cycDone + CNT_W'(1)) == cfg.cycCount;
  assign drvLine     = cfg.lineSel;
  assign busy        = state != ST_IDLE;
  assign active      = state == ST_RUN;

  always_comb begin
    case (cfg.pattern)
      PAT_RISE, PAT_HIGHPULSE, PAT_HIGHTRAIN: actLvl = 1'b1;
      PAT_LEVEL:                              actLvl = cfg.levelVal;
      default:                                actLvl = 1'b0;
    endcase
  end

  always_comb begin
    drvEn    = 1'b0;
    drvLevel = actLvl;
    evDone   = 1'b0;
    evErr    = 1'b0;
    if (strobe.halt || strobe.disarm) begin
      drvEn = 1'b0;
    end else if (strobe.arm) begin
      evErr = inPast;
    end else if (state == ST_WAIT) begin
      if (reached) begin
        drvEn  = cfg.pattern != PAT_NONE;
        evDone = !isTrain && !isPulse;
      end
    end else if (state == ST_RUN) begin
      if (perEnd) begin
        drvEn = 1'b1;
        if (lastCyc) begin
          drvLevel = !actLvl;
          evDone   = 1'b1;
        end
      end else if (pulEnd) begin
        drvEn    = 1'b1;
        drvLevel = !actLvl;
        evDone   = isPulse;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      elapsed <= '0;
      cycDone <= '0;
    end else if (strobe.halt || strobe.disarm) begin
      state <= ST_IDLE;
    end else if (strobe.arm) begin
      state <= inPast ? ST_IDLE : ST_WAIT;
    end else begin
      case (state)
        ST_WAIT: if (reached) begin
          state   <= (isTrain || isPulse) ? ST_RUN : ST_IDLE;
          elapsed <= '0;
          cycDone <= '0;
        end
        ST_RUN: begin
          if (evDone) begin
            state <= ST_IDLE;
          end else if (perEnd) begin
            elapsed <= '0;
            cycDone <= cycDone + CNT_W'(1);
          end else if (todTick) begin
            elapsed <= elapsedNext;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trig_lines.sv
module trig_lines
  import trig_pkg::*;
#(
  parameter int NUM_UNITS = 3,
  parameter int NUM_LINES = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_UNITS-1:0]              drvEn,
  input  logic [NUM_UNITS-1:0][LSEL_W-1:0]  drvLine,
  input  logic [NUM_UNITS-1:0]              drvLevel,
  output logic [NUM_LINES-1:0]              lineLevel
);
  logic [NUM_LINES-1:0] nextLevel;

  always_comb begin
    nextLevel = lineLevel;
    for (int l = 0; l < NUM_LINES; l++) begin
      for (int u = NUM_UNITS - 1; u >= 0; u--) begin
        if (drvEn[u] && drvLine[u] == LSEL_W'(l)) nextLevel[l] = drvLevel[u];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineLevel <= '0;
    else       lineLevel <= nextLevel;
  end
endmodule

// File: rtl/trig_out_bank.sv
module trig_out_bank
  import trig_pkg::*;
#(
  parameter int NUM_UNITS = 3,
  parameter int NUM_LINES = 4,
  parameter int ADDR_W    = 6,
  parameter int IDX_W     = 2,
  parameter int SEC_W     = 32,
  parameter int NS_W      = 30
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SEC_W-1:0]     todSec,
  input  logic [NS_W-1:0]      todNs,
  input  logic                 todTick,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  output logic [NUM_LINES-1:0] outLines,
  output logic                 irq
);
  unit_cfg_t    [NUM_UNITS-1:0]             unitCfg;
  unit_strobe_t [NUM_UNITS-1:0]             strobe;
  logic         [NUM_UNITS-1:0]             evDone, evErr, unitBusy, unitActive;
  logic         [NUM_UNITS-1:0]             errFlags, doneFlags, intFlags;
  logic         [NUM_UNITS-1:0]             drvEn, drvLevel;
  logic         [NUM_UNITS-1:0][LSEL_W-1:0] drvLine;

  trig_ctrl #(.NUM_UNITS(NUM_UNITS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .evDone(evDone), .evErr(evErr),
    .unitBusy(unitBusy), .unitActive(unitActive), .unitCfg(unitCfg),
    .strobe(strobe), .errFlags(errFlags), .doneFlags(doneFlags),
    .intFlags(intFlags), .irq(irq)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    trig_unit #(.SEC_W(SEC_W), .NS_W(NS_W)) i_unit (
      .clk(clk), .rstN(rstN), .strobe(strobe[u]), .cfg(unitCfg[u]),
      .todSec(todSec), .todNs(todNs), .todTick(todTick),
      .drvEn(drvEn[u]), .drvLine(drvLine[u]), .drvLevel(drvLevel[u]),
      .evDone(evDone[u]), .evErr(evErr[u]), .busy(unitBusy[u]),
      .active(unitActive[u])
    );
  end

  trig_lines #(.NUM_UNITS(NUM_UNITS), .NUM_LINES(NUM_LINES)) i_lines (
    .clk(clk), .rstN(rstN), .drvEn(drvEn), .drvLine(drvLine),
    .drvLevel(drvLevel), .lineLevel(outLines)
  );
endmodule

// File: rtl/trig_out_bank_chk.sv
module trig_out_bank_chk
  import trig_pkg::*;
#(
  parameter int NUM_UNITS = 3,
  parameter int NUM_LINES = 4,
  parameter int ADDR_W    = 6
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          regWrEn,
  input logic [ADDR_W-1:0]             regAddr,
  input logic [31:0]                   regWdata,
  input logic [NUM_LINES-1:0]          outLines,
  input logic                          irq,
  input logic [NUM_UNITS-1:0]          evDone,
  input logic [NUM_UNITS-1:0]          evErr,
  input logic [NUM_UNITS-1:0]          unitBusy,
  input logic [NUM_UNITS-1:0]          errFlags,
  input unit_cfg_t [NUM_UNITS-1:0]     unitCfg
);
  logic haltWr;
  assign haltWr = regWrEn && regAddr == ADDR_W'(OFS_CTRL) && regWdata[0];

  AST_HALT_HOLDS_LINES: assert property (@(posedge clk) disable iff (!rstN)
    haltWr |=> $stable(outLines)); // R11
  AST_HALT_IDLES_ALL: assert property (@(posedge clk) disable iff (!rstN)
    haltWr |=> unitBusy == '0); // R11
  AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(|evDone)); // R8

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
    AST_PAST_TARGET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      evErr[u] |=> !unitBusy[u]); // R9
    AST_ENDLESS_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
      (evDone[u] && (unitCfg[u].pattern == PAT_LOWTRAIN || unitCfg[u].pattern == PAT_HIGHTRAIN))
        |-> unitCfg[u].cycCount != '0); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (errFlags[u] && !(regWrEn && regAddr == ADDR_W'(OFS_TSTAT) && regWdata[FLAG_HI+u]))
        |=> errFlags[u]); // R10
  end
endmodule

bind trig_out_bank trig_out_bank_chk #(
  .NUM_UNITS(NUM_UNITS), .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWdata(regWdata), .outLines(outLines), .irq(irq), .evDone(evDone),
  .evErr(evErr), .unitBusy(unitBusy), .errFlags(errFlags), .unitCfg(unitCfg)
);

// File: tb/test_trig_out_bank.sv
module test_trig_out_bank;
  import trig_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] todSec = 32'd5;
  logic [29:0] todNs = 30'd0;
  logic        todTick = 1'b1;
  logic        regWrEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [3:0]  outLines;
  logic        irq;

  int errs = 0, checks = 0;
  bit finished = 0;
  logic   samp [0:255];
  longint todAt [0:255];

  always #5 clk = ~clk;

  trig_out_bank i_trig_out_bank (
    .clk(clk), .rstN(rstN), .todSec(todSec), .todNs(todNs), .todTick(todTick),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .outLines(outLines), .irq(irq)
  );

  always @(posedge clk) begin
    #2;
    if (int'(todNs) + 8 >= 1000000000) begin
      todNs  = todNs + 30'd8 - 30'd1000000000;
      todSec = todSec + 32'd1;
    end else begin
      todNs = todNs + 30'd8;
    end
  end

  function automatic longint nowAbs();
    return longint'(todSec) * 64'd1000000000 + longint'(todNs);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    regAddr = 6'(a); regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    regAddr = 6'(a);
    #1 d = regRdata;
  endtask

  task automatic clrStatus();
    wr(OFS_TSTAT, 32'h0007_0007);
    wr(OFS_ISTAT, 32'h0007_0000);
  endtask

  task automatic setTod(input int s, input int n);
    @(negedge clk);
    todSec = 32'(s); todNs = 30'(n);
  endtask

  task automatic arm(input int sel, input int pat, input int line, input bit ntf,
                     input bit lvl, input int period, input int cnt, input int width,
                     input longint tgt);
    wr(OFS_SEL, 32'(sel));
    wr(OFS_SETUP, {22'b0, lvl, ntf, 4'(line), 1'b0, 3'(pat)});
    wr(OFS_PERIOD, 32'(period));
    wr(OFS_CNT, {16'(cnt), 16'b0});
    wr(OFS_WIDTH, 32'(width));
    wr(OFS_TNS, 32'(tgt % 1000000000));
    wr(OFS_TSEC, 32'(tgt / 1000000000));
    wr(OFS_CTRL, 32'h6);
  endtask

  task automatic capture(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      samp[i]  = outLines[idx];
      todAt[i] = nowAbs();
    end
  endtask

  task automatic analyze(input int n, input logic act, output longint firstT,
                         output int runs, output int firstLen, output int spacing,
                         output int flips);
    int s1 = -1, s2 = -1;
    firstT = -1; runs = 0; firstLen = 0; flips = 0;
    for (int i = 0; i < n; i++) begin
      if (i > 0 && samp[i] != samp[i-1]) flips++;
      if (samp[i] == act && (i == 0 || samp[i-1] != act)) begin
        runs++;
        if (s1 < 0) begin s1 = i; firstT = todAt[i]; end
        else if (s2 < 0) s2 = i;
      end
      if (runs == 1 && samp[i] == act) firstLen++;
    end
    spacing = (s2 >= 0) ? s2 - s1 : 0;
  endtask

  function automatic longint expectFirst(input longint tgt);
    return ((tgt + 7) / 8) * 8 + 8;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    longint tgt, firstT;
    int runs, len, spc, flips;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 lines", outLines, 0);
    chk("R1 irq", irq, 0);
    rd(OFS_TSTAT, d); chk("R1 tstat", d, 0);
    rd(OFS_ISTAT, d); chk("R1 istat", d, 0);

    // R2 unit selection of per-unit registers
    wr(OFS_SEL, 1); wr(OFS_TNS, 32'h1234);
    wr(OFS_SEL, 2); wr(OFS_TNS, 32'h5678);
    wr(OFS_SEL, 3); wr(OFS_TNS, 32'h9999);
    rd(OFS_TNS, d); chk("R2 sel3 reads zero", d, 0);
    wr(OFS_SEL, 1); rd(OFS_TNS, d); chk("R2 unit1 target", d, 32'h1234);
    wr(OFS_SEL, 2); rd(OFS_TNS, d); chk("R2 unit2 target", d, 32'h5678);
    wr(OFS_WIDTH, 32'hFFFF_FFFF); rd(OFS_WIDTH, d); chk("R2 width field", d, 32'h00FF_FFFF);

    // R3 / R4 rising step, no notify
    tgt = nowAbs() + 603;
    arm(0, 1, 1, 0, 0, 0, 0, 0, tgt);
    capture(1, 90);
    analyze(90, 1'b1, firstT, runs, len, spc, flips);
    chk("R3 rising event time", firstT, expectFirst(tgt));
    chk("R4 rising level", samp[89], 1);
    rd(OFS_TSTAT, d); chk("R4 done unit0", d, 32'h1);
    rd(OFS_ISTAT, d); chk("R8 no notify no int", d, 0);

    // R4 falling step with notify, R8 interrupt, R10 clear
    clrStatus();
    tgt = nowAbs() + 600;
    arm(0, 0, 1, 1, 0, 0, 0, 0, tgt);
    capture(1, 90);
    analyze(90, 1'b0, firstT, runs, len, spc, flips);
    chk("R4 falling event time", firstT, expectFirst(tgt));
    chk("R4 falling level", samp[89], 0);
    rd(OFS_ISTAT, d); chk("R8 int flag unit0", d, 32'h0001_0000);
    chk("R8 irq high", irq, 1);
    wr(OFS_TSTAT, 32'h0000_0001); rd(OFS_TSTAT, d); chk("R10 done cleared", d, 0);
    wr(OFS_ISTAT, 32'h0001_0000); rd(OFS_ISTAT, d); chk("R10 int cleared", d, 0);
    @(negedge clk); chk("R10 irq low", irq, 0);

    // R4 level mode on line 2
    tgt = nowAbs() + 600;
    arm(1, 6, 2, 0, 1, 0, 0, 0, tgt);
    capture(2, 90);
    chk("R4 level drive", samp[89], 1);
    rd(OFS_TSTAT, d); chk("R4 level done", d, 32'h2);
    clrStatus();

    // R5 low pulse width 3 on line 2
    tgt = nowAbs() + 600;
    arm(2, 2, 2, 0, 0, 0, 0, 3, tgt);
    capture(2, 100);
    analyze(100, 1'b0, firstT, runs, len, spc, flips);
    chk("R5 low pulse count", runs, 1);
    chk("R5 low pulse length", len, 3);
    chk("R5 low pulse start", firstT, expectFirst(tgt));
    chk("R5 returns idle", samp[99], 1);
    rd(OFS_TSTAT, d); chk("R5 done unit2", d, 32'h4);
    clrStatus();

    // R5 high pulse width 5 on line 3
    tgt = nowAbs() + 600;
    arm(0, 3, 3, 0, 0, 0, 0, 5, tgt);
    capture(3, 100);
    analyze(100, 1'b1, firstT, runs, len, spc, flips);
    chk("R5 high pulse length", len, 5);
    chk("R5 high pulse count", runs, 1);
    clrStatus();

    // R6 high train: period 80 ns, width 3, count 4, notify
    tgt = nowAbs() + 600;
    arm(1, 5, 0, 1, 0, 80, 4, 3, tgt);
    capture(0, 140);
    analyze(140, 1'b1, firstT, runs, len, spc, flips);
    chk("R6 train pulses", runs, 4);
    chk("R6 train width", len, 3);
    chk("R6 train spacing", spc, 10);
    chk("R6 train start", firstT, expectFirst(tgt));
    chk("R6 train ends idle", samp[139], 0);
    rd(OFS_TSTAT, d); chk("R6 done unit1", d, 32'h2);
    rd(OFS_ISTAT, d); chk("R8 train int", d, 32'h0002_0000);
    clrStatus();

    // R6 width above period: solid for 3 periods of 5 ticks
    tgt = nowAbs() + 600;
    arm(0, 5, 3, 0, 0, 40, 3, 8, tgt);
    capture(3, 100);
    analyze(100, 1'b1, firstT, runs, len, spc, flips);
    chk("R6 wide runs", runs, 1);
    chk("R6 wide length", len, 15);
    clrStatus();

    // R7 endless low train on line 2 (idle high), then R12 disarm
    tgt = nowAbs() + 600;
    arm(2, 4, 2, 1, 0, 64, 0, 2, tgt);
    capture(2, 160);
    analyze(160, 1'b0, firstT, runs, len, spc, flips);
    chk("R7 endless many pulses", (runs >= 12) ? 1 : 0, 1);
    chk("R7 endless spacing", spc, 8);
    rd(OFS_TSTAT, d); chk("R7 no done", d, 0);
    rd(OFS_CTRL, d); chk("R12 enabled and running", d & 32'hA, 32'hA);
    wr(OFS_CTRL, 32'h0);
    capture(2, 40);
    analyze(40, 1'b0, firstT, runs, len, spc, flips);
    chk("R12 disarm freezes line", flips, 0);
    rd(OFS_CTRL, d); chk("R12 enable cleared", d & 32'hA, 0);

    // R9 past target: error, no output on line 0
    clrStatus();
    tgt = nowAbs() - 80;
    arm(0, 1, 0, 1, 0, 0, 0, 0, tgt);
    capture(0, 40);
    analyze(40, 1'b1, firstT, runs, len, spc, flips);
    chk("R9 no output", runs, 0);
    rd(OFS_TSTAT, d); chk("R9 error flag", d, 32'h0001_0000);
    rd(OFS_CTRL, d); chk("R9 not enabled", d & 32'h2, 0);
    wr(OFS_TSTAT, 32'h0001_0000); rd(OFS_TSTAT, d); chk("R10 error cleared", d, 0);

    // R11 halt during the active phase keeps the level
    tgt = nowAbs() + 600;
    arm(1, 5, 0, 0, 0, 160, 0, 10, tgt);
    for (int i = 0; i < 200 && outLines[0] == 1'b0; i++) @(negedge clk);
    chk("R11 train started", outLines[0], 1);
    wr(OFS_CTRL, 32'h1);
    capture(0, 60);
    analyze(60, 1'b1, firstT, runs, len, spc, flips);
    chk("R11 no change after halt", flips, 0);
    chk("R11 level kept", samp[59], 1);
    for (int u = 0; u < 3; u++) begin
      wr(OFS_SEL, 32'(u));
      rd(OFS_CTRL, d);
      chk("R11 enable cleared", d & 32'h2, 0);
    end

    // R3 target just past a seconds boundary
    setTod(5, 999999600);
    tgt = 64'd6000000016;
    arm(0, 1, 3, 0, 0, 0, 0, 0, tgt);
    capture(3, 100);
    analyze(100, 1'b1, firstT, runs, len, spc, flips);
    chk("R3 seconds crossing time", firstT, 64'd6000000024);

    finished = 1;
    summary();
    $finish;
  end
endmodule